// File: doc/BRIEF.md
# Timed State Sequencer with Dwell Windows

This block steps one task through a table of timed states held in a parameter. Every row gives the state's kind (start, working, super or final), the precondition that must hold to enter it, a minimum and a maximum dwell time counted in ticks of an external tick strobe, up to two successor slots and a flag that says whether a timeout path is defined. The precondition of a row is one input bit chosen by a kind and a select: an interrupt line, a signal line, a timer strobe or a boolean condition line.

While a state is occupied the block counts ticks. It looks at the successors only once the minimum dwell has been reached. If no successor is ready by the time the maximum dwell runs out, the block pulses its timeout strobe and goes back to the root start state. It also sets a sticky error flag when the state defines no timeout path. Entering a superstate moves control into its subchart. When that subchart's final state ends, control continues at the successor the superstate names for the return. An on-demand start request re-enters the root start state from anywhere.

Top module: `seq_task_top`

## Requirements
- R1: While reset is held (active-low, synchronous) and on the first cycle after it, the state output is 0, the action strobe and the timeout strobe are 0 and the error flag is 0.
- R2: A successor is taken only when its precondition bit is 1 and the current state has seen at least its minimum dwell in ticks. Before that, a ready precondition leaves the state unchanged.
- R3: If more than one successor slot is ready in the same cycle, the successor with the lowest table index is entered.
- R4: With maximum dwell M > 0 and no successor taken, the M-th tick after entry gives a one-cycle timeout strobe, and the state returns to 0. This happens even inside a subchart. M = 0 never times out. A successor that is ready in the same cycle as the expiring tick wins over the timeout.
- R5: A timeout in a state without a timeout path sets the error flag, and it stays set until reset. A timeout in a state with a timeout path leaves the flag unchanged.
- R6: A final state needs no precondition. Once its minimum dwell has passed it moves on, to state 0 when at top level.
- R7: Selecting a superstate enters the start state of its subchart, so a super row is never the current state. The subchart's final state then continues at the superstate's return successor.
- R8: The start request sends the block to state 0 from any state. It has priority over successors, final advance and timeout.
- R9: The action strobe is 1 for exactly the one cycle after each state entry, including re-entry into state 0. It is 0 while the state is held and at reset.
- R10: Precondition kinds are encoded as 0 interrupt, 1 signal, 2 timer strobe and 3 condition. The select picks the bit of that vector, and no other bit of any vector counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_req | input | 1 | On-demand entry into the root start state |
| tick | input | 1 | Time base strobe, one count per high cycle |
| irq_in | input | N_IRQ | Interrupt lines (precondition kind 0) |
| sig_in | input | N_SIG | Internal signal lines (kind 1) |
| tmr_in | input | N_TMR | Timer strobes (kind 2) |
| cond_in | input | N_COND | Boolean condition lines (kind 3) |
| state_o | output | 3 | Index of the current state |
| act_stb_o | output | 1 | One-cycle pulse on each state entry |
| tmo_stb_o | output | 1 | One-cycle pulse when a maximum dwell expires |
| err_o | output | 1 | Sticky flag: timeout with no timeout path |

## Verification
The hardest cases to reach are the ones where two timing rules meet on the same tick. One is a successor precondition that rises exactly on the tick where the maximum dwell runs out. Another is a timeout while the block is inside a subchart, which must land on the root start state and not on the return successor. The stimulus reaches these by counting ticks from the observed entry strobe. It drives the precondition together with the M-th tick, and it enters the subchart through a signal line followed by a timer strobe before it lets the ticks run out.

// File: rtl/seq_pkg.sv
// Shared types for the timed state sequencer: state kinds, precondition
// kinds, the packed table row and a default table for elaboration.
// Assumes state indices fit in SW bits and times fit in TW bits.
package seq_pkg;
    localparam int SW       = 3;   // state index width
    localparam int TW       = 8;   // dwell time width in ticks
    localparam int PIW      = 2;   // precondition select width
    localparam int N_SLOT   = 2;   // successor slots per row
    localparam int N_ST_DEF = 8;   // rows in the default table

    typedef enum logic [1:0] {K_START = 2'd0, K_WORK = 2'd1,
                              K_SUPER = 2'd2, K_FINAL = 2'd3} kind_e;
    typedef enum logic [1:0] {P_IRQ = 2'd0, P_SIG = 2'd1,
                              P_TMR = 2'd2, P_COND = 2'd3} pre_e;

    typedef struct packed {
        kind_e                         kind;
        pre_e                          pre;      // entry precondition kind
        logic [PIW-1:0]                pre_sel;  // bit within that vector
        logic [TW-1:0]                 min_t;
        logic [TW-1:0]                 max_t;    // 0: no timeout
        logic [N_SLOT-1:0][SW-1:0]     nxt;
        logic [N_SLOT-1:0]             nxt_v;
        logic                          on_to;    // timeout path defined
        logic [SW-1:0]                 sub_go;   // super: subchart start
        logic [SW-1:0]                 sub_ret;  // super: return successor
    } st_row_t;

    typedef st_row_t [N_ST_DEF-1:0] tbl_def_t;

    // Builds one table row from plain integers.
    function automatic st_row_t mk(kind_e k, pre_e p, int sel, int mn, int mx,
                                   int n0, int n1, logic v0, logic v1,
                                   logic ta, int sg, int sr);
        st_row_t r;
        r.kind    = k;
        r.pre     = p;
        r.pre_sel = PIW'(sel);
        r.min_t   = TW'(mn);
        r.max_t   = TW'(mx);
        r.nxt[0]  = SW'(n0);
        r.nxt[1]  = SW'(n1);
        r.nxt_v   = {v1, v0};
        r.on_to   = ta;
        r.sub_go  = SW'(sg);
        r.sub_ret = SW'(sr);
        return r;
    endfunction

    // Default task: a root chart with one superstate and a short subchart.
    function automatic tbl_def_t def_table();
        tbl_def_t t;
        t[0] = mk(K_START, P_IRQ,  0, 0, 0, 1, 2, 1'b1, 1'b1, 1'b0, 0, 0);
        t[1] = mk(K_WORK,  P_IRQ,  0, 2, 5, 3, 7, 1'b1, 1'b1, 1'b1, 0, 0);
        t[2] = mk(K_SUPER, P_SIG,  1, 0, 0, 0, 0, 1'b0, 1'b0, 1'b0, 4, 7);
        t[3] = mk(K_WORK,  P_COND, 0, 0, 3, 7, 0, 1'b1, 1'b0, 1'b0, 0, 0);
        t[4] = mk(K_START, P_IRQ,  3, 0, 0, 5, 0, 1'b1, 1'b0, 1'b0, 0, 0);
        t[5] = mk(K_WORK,  P_TMR,  0, 1, 4, 6, 0, 1'b1, 1'b0, 1'b1, 0, 0);
        t[6] = mk(K_FINAL, P_COND, 1, 2, 0, 0, 0, 1'b0, 1'b0, 1'b0, 0, 0);
        t[7] = mk(K_FINAL, P_COND, 2, 1, 0, 0, 0, 1'b0, 1'b0, 1'b0, 0, 0);
        return t;
    endfunction
endpackage

// File: rtl/seq_pre_eval.sv
// Precondition evaluator: picks one input bit by kind and select.
// Assumes select values beyond a vector's width read as false.
module seq_pre_eval #(
    parameter int N_IRQ  = 4,
    parameter int N_SIG  = 4,
    parameter int N_TMR  = 4,
    parameter int N_COND = 4
) (
    input  seq_pkg::pre_e              pre_i,
    input  logic [seq_pkg::PIW-1:0]    sel_i,
    input  logic [N_IRQ-1:0]           irq_i,
    input  logic [N_SIG-1:0]           sig_i,
    input  logic [N_TMR-1:0]           tmr_i,
    input  logic [N_COND-1:0]          cond_i,
    output logic                       hit_o
);
    localparam int SELV = int'(seq_pkg::PIW);

    // Route the addressed bit of the addressed vector to the output.
    always_comb begin
        hit_o = 1'b0;
        for (int b = 0; b < (1 << SELV); b++) begin
            if (int'(sel_i) == b) begin
                unique case (pre_i)
                    seq_pkg::P_IRQ:  hit_o = (b < N_IRQ)  ? irq_i[b % N_IRQ]   : 1'b0;
                    seq_pkg::P_SIG:  hit_o = (b < N_SIG)  ? sig_i[b % N_SIG]   : 1'b0;
                    seq_pkg::P_TMR:  hit_o = (b < N_TMR)  ? tmr_i[b % N_TMR]   : 1'b0;
                    default:         hit_o = (b < N_COND) ? cond_i[b % N_COND] : 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/seq_slot_pick.sv
// Successor arbiter: among ready slots, returns the lowest target index.
// Assumes any_o low means idx_o is don't-care.
module seq_slot_pick #(
    parameter int N_SLOT = 2,
    parameter int SW     = 3
) (
    input  logic [N_SLOT-1:0]          rdy_i,
    input  logic [N_SLOT-1:0][SW-1:0]  idx_i,
    output logic                       any_o,
    output logic [SW-1:0]              idx_o
);
    // Linear scan keeping the smallest ready index.
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int s = 0; s < N_SLOT; s++) begin
            if (rdy_i[s] && (!any_o || idx_i[s] < idx_o)) begin
                any_o = 1'b1;
                idx_o = idx_i[s];
            end
        end
    end
endmodule

// File: rtl/seq_dwell.sv
// Dwell timer: counts ticks since state entry (saturating) and a timeout
// down-counter loaded with the maximum dwell on entry. Zero never expires.
module seq_dwell #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart_i,   // state entry this cycle
    input  logic          tick_i,
    input  logic [TW-1:0] load_max_i,  // max dwell of the state being entered
    input  logic [TW-1:0] rst_max_i,   // max dwell of the reset state
    input  logic [TW-1:0] min_t_i,     // min dwell of the current state
    output logic          min_ok_o,
    output logic          expire_o
);
    logic [TW-1:0] elapsed_q;
    logic [TW-1:0] left_q;
    logic          armed_q;

    // Elapsed and remaining tick counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elapsed_q <= '0;
            left_q    <= rst_max_i;
        end else if (restart_i) begin
            elapsed_q <= '0;
            left_q    <= load_max_i;
        end else if (tick_i) begin
            if (elapsed_q != {TW{1'b1}}) elapsed_q <= elapsed_q + 1'b1;
            if (left_q != '0)            left_q    <= left_q - 1'b1;
        end
    end

    // Marks cycles whose previous edge was already out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    assign min_ok_o = (elapsed_q >= min_t_i);
    assign expire_o = tick_i && (left_q == {{(TW-1){1'b0}}, 1'b1});

    // R2: elapsed time only grows while a state is held
    a_r2_elapsed_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !$past(restart_i)) |-> (elapsed_q >= $past(elapsed_q)));

    // R4: after an expiring tick the remaining count is zero or reloaded
    a_r4_expire_drains: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && !restart_i) |=> (left_q == '0));
endmodule

// File: rtl/seq_task_top.sv
// Timed state sequencer top: holds the current state, evaluates successor
// preconditions once the minimum dwell has passed, handles timeout, final
// advance, one level of subchart entry/return and on-demand start.
// Assumes the table keeps superstates out of subcharts.
module seq_task_top #(
    parameter int N_ST   = seq_pkg::N_ST_DEF,
    parameter int N_IRQ  = 4,
    parameter int N_SIG  = 4,
    parameter int N_TMR  = 4,
    parameter int N_COND = 4,
    parameter seq_pkg::st_row_t [N_ST-1:0] TABLE = seq_pkg::def_table()
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_req,
    input  logic                     tick,
    input  logic [N_IRQ-1:0]         irq_in,
    input  logic [N_SIG-1:0]         sig_in,
    input  logic [N_TMR-1:0]         tmr_in,
    input  logic [N_COND-1:0]        cond_in,
    output logic [seq_pkg::SW-1:0]   state_o,
    output logic                     act_stb_o,
    output logic                     tmo_stb_o,
    output logic                     err_o
);
    import seq_pkg::*;
    localparam int NS = seq_pkg::N_SLOT;

    logic [SW-1:0]          cur_q, ret_q, nxt, ret_d;
    logic                   in_sub_q, sub_d;
    logic                   act_q, tmo_q, err_q, armed_q;
    logic                   go, to_hit;
    logic                   min_ok, expire;
    logic [NS-1:0]          slot_rdy;
    logic [NS-1:0][SW-1:0]  slot_idx;
    logic                   any_rdy;
    logic [SW-1:0]          pick;

    // One precondition evaluator per successor slot.
    for (genvar s = 0; s < NS; s++) begin : g_slot
        logic [SW-1:0] tgt;
        logic          hit;
        assign tgt = TABLE[cur_q].nxt[s];
        seq_pre_eval #(.N_IRQ(N_IRQ), .N_SIG(N_SIG), .N_TMR(N_TMR), .N_COND(N_COND)) u_pre (
            .pre_i  (TABLE[tgt].pre),
            .sel_i  (TABLE[tgt].pre_sel),
            .irq_i  (irq_in),
            .sig_i  (sig_in),
            .tmr_i  (tmr_in),
            .cond_i (cond_in),
            .hit_o  (hit)
        );
        assign slot_rdy[s] = TABLE[cur_q].nxt_v[s] & hit;
        assign slot_idx[s] = tgt;
    end

    seq_slot_pick #(.N_SLOT(NS), .SW(SW)) u_pick (
        .rdy_i (slot_rdy),
        .idx_i (slot_idx),
        .any_o (any_rdy),
        .idx_o (pick)
    );

    seq_dwell #(.TW(TW)) u_dwell (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart_i  (go),
        .tick_i     (tick),
        .load_max_i (TABLE[nxt].max_t),
        .rst_max_i  (TABLE[0].max_t),
        .min_t_i    (TABLE[cur_q].min_t),
        .min_ok_o   (min_ok),
        .expire_o   (expire)
    );

    // Next-state decision: start request, final advance, successor, timeout.
    always_comb begin
        go     = 1'b0;
        to_hit = 1'b0;
        nxt    = cur_q;
        sub_d  = in_sub_q;
        ret_d  = ret_q;
        if (start_req) begin
            go    = 1'b1;
            nxt   = '0;
            sub_d = 1'b0;
        end else if (TABLE[cur_q].kind == K_FINAL) begin
            if (min_ok) begin
                go    = 1'b1;
                nxt   = in_sub_q ? ret_q : '0;
                sub_d = 1'b0;
            end
        end else if (min_ok && any_rdy) begin
            go = 1'b1;
            if (TABLE[pick].kind == K_SUPER) begin
                nxt   = TABLE[pick].sub_go;
                sub_d = 1'b1;
                ret_d = TABLE[pick].sub_ret;
            end else begin
                nxt = pick;
            end
        end else if (expire) begin
            go     = 1'b1;
            to_hit = 1'b1;
            nxt    = '0;
            sub_d  = 1'b0;
        end
    end

    // State, subchart context and output strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q    <= '0;
            ret_q    <= '0;
            in_sub_q <= 1'b0;
            act_q    <= 1'b0;
            tmo_q    <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            cur_q    <= nxt;
            ret_q    <= ret_d;
            in_sub_q <= sub_d;
            act_q    <= go;
            tmo_q    <= to_hit;
            err_q    <= err_q | (to_hit & ~TABLE[cur_q].on_to);
        end
    end

    // Marks cycles whose previous edge was already out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    assign state_o   = cur_q;
    assign act_stb_o = act_q;
    assign tmo_stb_o = tmo_q;
    assign err_o     = err_q;

    // R5: the error flag never clears outside reset
    a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);

    // R9: any change of state comes with an entry strobe
    a_r9_act_on_move: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && (cur_q != $past(cur_q))) |-> act_q);

    // R4: a timeout always lands on the root start state as an entry
    a_r4_tmo_to_root: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_q |-> (cur_q == '0 && act_q));

    // R7: a superstate row is never occupied
    a_r7_never_super: assert property (@(posedge clk) disable iff (!rst_n)
        TABLE[cur_q].kind != K_SUPER);

    // R8: a start request always re-enters state 0
    a_r8_start_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(start_req)) |-> (cur_q == '0 && act_q && !tmo_q));
endmodule

// File: tb/seq_task_top_tb_top.sv
// Bench: a vector table walked cycle by cycle, then directed corner tests.
module seq_task_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_req = 1'b0, tick = 1'b0;
    logic [3:0] irq_in = '0, sig_in = '0, tmr_in = '0, cond_in = '0;
    logic [2:0] state_o;
    logic       act_stb_o, tmo_stb_o, err_o;
    int         n_chk = 0, n_fail = 0;
    logic       done = 1'b0;

    always #5 clk = ~clk;

    seq_task_top dut_i (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .tick(tick),
        .irq_in(irq_in), .sig_in(sig_in), .tmr_in(tmr_in), .cond_in(cond_in),
        .state_o(state_o), .act_stb_o(act_stb_o), .tmo_stb_o(tmo_stb_o), .err_o(err_o)
    );

    typedef struct packed {
        logic       st, tk;
        logic [3:0] irq, sig, tmr, cond;
        logic [2:0] cur;
        logic       act, to, err;
        logic [3:0] req;
    } vec_t;

    // Default table: 0 start ->1(irq0),2(sig1); 1 work min2 max5 ->3(cond0),7(cond2);
    // 2 super -> sub 4, return 7; 3 work max3 no timeout path ->7;
    // 4 sub start ->5(tmr0); 5 work min1 max4 ->6(cond1); 6 final min2; 7 final min1.
    localparam vec_t VEC [22] = '{
        '{1'b0,1'b0,4'h1,4'h0,4'h0,4'h0,3'd1,1'b1,1'b0,1'b0,4'd10}, // R10 irq0 enters 1
        '{1'b0,1'b0,4'h0,4'h0,4'h0,4'h1,3'd1,1'b0,1'b0,1'b0,4'd2},  // R2 cond0 before min
        '{1'b0,1'b1,4'h0,4'h0,4'h0,4'h1,3'd1,1'b0,1'b0,1'b0,4'd2},  // R2 first tick
        '{1'b0,1'b1,4'h0,4'h0,4'h0,4'h0,3'd1,1'b0,1'b0,1'b0,4'd9},  // R9 hold, no strobe
        '{1'b0,1'b0,4'h0,4'h0,4'h0,4'h5,3'd3,1'b1,1'b0,1'b0,4'd3},  // R3 3 beats 7
        '{1'b0,1'b1,4'h0,4'h0,4'h0,4'h0,3'd3,1'b0,1'b0,1'b0,4'd4},
        '{1'b0,1'b1,4'h0,4'h0,4'h0,4'h0,3'd3,1'b0,1'b0,1'b0,4'd4},
        '{1'b0,1'b1,4'h0,4'h0,4'h0,4'h0,3'd0,1'b1,1'b1,1'b1,4'd5},  // R5 timeout, no path
        '{1'b0,1'b0,4'h0,4'h2,4'h0,4'h0,3'd4,1'b1,1'b0,1'b1,4'd7},  // R7 super -> sub start
        '{1'b0,1'b0,4'h0,4'h0,4'h1,4'h0,3'd5,1'b1,1'b0,1'b1,4'd10}, // R10 timer strobe
        '{1'b0,1'b0,4'h0,4'h0,4'h0,4'h2,3'd5,1'b0,1'b0,1'b1,4'd2},
        '{1'b0,1'b1,4'h0,4'h0,4'h0,4'h2,3'd5,1'b0,1'b0,1'b1,4'd2},
        '{1'b0,1'b0,4'h0,4'h0,4'h0,4'h2,3'd6,1'b1,1'b0,1'b1,4'd2},
        '{1'b0,1'b1,4'h0,4'h0,4'h0,4'h0,3'd6,1'b0,1'b0,1'b1,4'd6},
        '{1'b0,1'b1,4'h0,4'h0,4'h0,4'h0,3'd6,1'b0,1'b0,1'b1,4'd6},
        '{1'b0,1'b0,4'h0,4'h0,4'h0,4'h0,3'd7,1'b1,1'b0,1'b1,4'd7},  // R7 return successor
        '{1'b0,1'b0,4'h0,4'h0,4'h0,4'h0,3'd7,1'b0,1'b0,1'b1,4'd6},
        '{1'b0,1'b1,4'h0,4'h0,4'h0,4'h0,3'd7,1'b0,1'b0,1'b1,4'd6},
        '{1'b0,1'b0,4'h0,4'h0,4'h0,4'h0,3'd0,1'b1,1'b0,1'b1,4'd6},  // R6 final -> 0
        '{1'b0,1'b0,4'h2,4'h1,4'h0,4'h0,3'd0,1'b0,1'b0,1'b1,4'd10}, // R10 wrong bits ignored
        '{1'b0,1'b0,4'h1,4'h2,4'h0,4'h0,3'd1,1'b1,1'b0,1'b1,4'd3},  // R3 1 beats 2
        '{1'b1,1'b0,4'h0,4'h0,4'h0,4'h1,3'd0,1'b1,1'b0,1'b1,4'd8}   // R8 start request
    };

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic apply(logic st, logic tk, logic [3:0] i, logic [3:0] s,
                         logic [3:0] t, logic [3:0] c);
        @(negedge clk);
        start_req = st; tick = tk; irq_in = i; sig_in = s; tmr_in = t; cond_in = c;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        apply(1'b0, 1'b0, 4'h0, 4'h0, 4'h0, 4'h0);
    endtask

    task automatic ticks(int n);
        for (int k = 0; k < n; k++) apply(1'b0, 1'b1, 4'h0, 4'h0, 4'h0, 4'h0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        start_req = 1'b0; tick = 1'b0; irq_in = '0; sig_in = '0; tmr_in = '0; cond_in = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "state in reset", int'(state_o), 0);
        chk("R1", "err in reset", int'(err_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        idle();
        chk("R1", "state after reset", int'(state_o), 0);
        chk("R1", "act after reset", int'(act_stb_o), 0);
        chk("R1", "tmo after reset", int'(tmo_stb_o), 0);
        chk("R1", "err after reset", int'(err_o), 0);

        for (int v = 0; v < 22; v++) begin
            string tag;
            apply(VEC[v].st, VEC[v].tk, VEC[v].irq, VEC[v].sig, VEC[v].tmr, VEC[v].cond);
            tag = $sformatf("R%0d vec%0d", VEC[v].req, v);
            chk(tag, "state", int'(state_o), int'(VEC[v].cur));
            chk(tag, "act", int'(act_stb_o), int'(VEC[v].act));
            chk(tag, "tmo", int'(tmo_stb_o), int'(VEC[v].to));
            chk(tag, "err", int'(err_o), int'(VEC[v].err));
        end

        // R1: reset clears the sticky error
        do_reset();
        idle();
        chk("R1", "err cleared", int'(err_o), 0);

        // R4/R5: timeout with a path returns to 0, strobes once, no error
        apply(1'b0, 1'b0, 4'h1, 4'h0, 4'h0, 4'h0);
        ticks(4);
        chk("R4", "state before expiry", int'(state_o), 1);
        chk("R4", "no early tmo", int'(tmo_stb_o), 0);
        ticks(1);
        chk("R4", "state at expiry", int'(state_o), 0);
        chk("R4", "tmo strobe", int'(tmo_stb_o), 1);
        chk("R5", "err with path", int'(err_o), 0);
        idle();
        chk("R4", "tmo one cycle", int'(tmo_stb_o), 0);

        // R4: successor ready on the expiring tick wins
        apply(1'b0, 1'b0, 4'h1, 4'h0, 4'h0, 4'h0);
        ticks(4);
        apply(1'b0, 1'b1, 4'h0, 4'h0, 4'h0, 4'h1);
        chk("R4", "successor beats timeout", int'(state_o), 3);
        chk("R4", "no tmo on tie", int'(tmo_stb_o), 0);
        apply(1'b1, 1'b0, 4'h0, 4'h0, 4'h0, 4'h0);
        chk("R8", "start from 3", int'(state_o), 0);

        // R4: max dwell of zero never expires
        ticks(20);
        chk("R4", "zero max holds", int'(state_o), 0);
        chk("R4", "zero max no tmo", int'(tmo_stb_o), 0);
        chk("R9", "no strobe while held", int'(act_stb_o), 0);

        // R7: timeout inside subchart goes to root start, not return successor
        apply(1'b0, 1'b0, 4'h0, 4'h2, 4'h0, 4'h0);
        chk("R7", "sub start", int'(state_o), 4);
        apply(1'b0, 1'b0, 4'h0, 4'h0, 4'h1, 4'h0);
        chk("R7", "sub work", int'(state_o), 5);
        ticks(4);
        chk("R7", "sub timeout to root", int'(state_o), 0);
        chk("R4", "sub tmo strobe", int'(tmo_stb_o), 1);
        chk("R5", "sub err with path", int'(err_o), 0);

        // R8: start request beats a ready successor and re-enters 0
        apply(1'b1, 1'b0, 4'h1, 4'h0, 4'h0, 4'h0);
        chk("R8", "start beats successor", int'(state_o), 0);
        chk("R9", "re-entry strobe", int'(act_stb_o), 1);
        apply(1'b0, 1'b0, 4'h1, 4'h0, 4'h0, 4'h0);
        ticks(2);
        apply(1'b1, 1'b0, 4'h0, 4'h0, 4'h0, 4'h1);
        chk("R8", "start beats ready cond", int'(state_o), 0);
        chk("R5", "err still clear", int'(err_o), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule